// File: doc/BRIEF.md
# 64-bit Rotate, Mask and Shift Unit

This purely combinational unit performs every rotate-with-mask and shift operation of a 64-bit integer pipeline. It takes a source operand and rotates it left. It then builds a bit mask from a begin position and an end position and keeps the rotated bits inside that mask. Bits outside the mask come from one of three places: zeros, copies of the sign bit, or a second "insert" operand. Five operation classes select how the mask is formed. Three of them rotate and then clear bits: both sides, the left side only, or the right side only. The other two are a left shift and a right shift. A word-mode flag selects the 32-bit forms, and an arithmetic flag turns the right shift into a sign-filling shift with a carry output.

Bit positions given to the unit use big-endian numbering: position 0 is the most significant bit (port bit 63) and position 63 is the least significant bit (port bit 0). The core pipeline instantiates one copy and drives it straight from decoded fields. The result is valid in the same cycle as the inputs.

Top module: `rms_unit`

## Requirements
- R1: With op_cls = 0 (rotate, clear both sides), result = rotl(src_a, n) & M, with n = shamt[5:0]. M has ones at big-endian positions mbeg..mend when mbeg <= mend. When mbeg > mend, M wraps around: ones from mbeg to 63 and from 0 to mend.
- R2: With op_cls = 1 (rotate, clear left), M has ones from mbeg to 63, and mend has no effect on the result.
- R3: With op_cls = 2 (rotate, clear right), M has ones from 0 to mend, and mbeg has no effect on the result.
- R4: With word_mode = 1 on a rotate class, the low 32 bits of src_a are copied into both halves before the rotate, and the rotate amount is shamt[4:0]. The mask positions are 32 + mbeg[4:0] and 32 + mend[4:0].
- R5: With merge_en = 1 on a rotate class, each result bit outside M equals the same bit of ins_b. With merge_en = 0 those bits are zero.
- R6: With op_cls = 3 (shift left), the result is src_a << shamt[5:0] in doubleword mode. In word mode it is {32'b0, src_a[31:0] << shamt[4:0]}, so the upper word is always zero.
- R7: With op_cls = 4 and arith = 0 (logical right shift), the result is src_a >> shamt[5:0] in doubleword mode. In word mode it is {32'b0, src_a[31:0] >> shamt[4:0]}.
- R8: With op_cls = 4 and arith = 1, vacated bits are filled with the sign bit. The sign bit is bit 63 in doubleword mode. In word mode it is bit 31, and the word result is sign-extended into the upper word.
- R9: A shift amount with its top bit set moves every bit out. That top bit is shamt[6] in doubleword mode and shamt[5] in word mode. The result is then all zeros for logical shifts and all copies of the sign bit for arithmetic shifts.
- R10: ca_out is 1 only for an arithmetic right shift of a negative operand where at least one 1 bit is shifted out. Otherwise it is 0.
- R11: Every rotate amount from 0 to 63 produces the correct rotation.
- R12: The unit holds no state. The same inputs always give the same outputs, and the outputs follow the inputs without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | Operand that is rotated or shifted |
| ins_b | input | 64 | Operand that supplies bits outside the mask in insert forms |
| shamt | input | 7 | Rotate or shift amount |
| mbeg | input | 6 | Mask begin position (big-endian) |
| mend | input | 6 | Mask end position (big-endian) |
| op_cls | input | 3 | Operation class: 0 both, 1 left, 2 right, 3 shift left, 4 shift right |
| word_mode | input | 1 | Selects the 32-bit forms |
| arith | input | 1 | Selects the arithmetic right shift |
| merge_en | input | 1 | Selects insert-under-mask for rotate classes |
| result | output | 64 | Operation result |
| ca_out | output | 1 | Carry from an arithmetic right shift |

## Verification
Both outputs are pure combinational functions of the present inputs, so every result is due zero cycles after its stimulus. The bench applies each vector on the falling clock edge and samples the outputs one time unit later, before the next rising edge. Applying the same vector again later, after other operations have run in between, must reproduce the earlier output. That is how the absence of state is checked. A reference function inside the bench recomputes each expected result from native shifts and a bit-by-bit mask loop.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [2:0] {
    RM_BOTH  = 3'd0,
    RM_LEFT  = 3'd1,
    RM_RIGHT = 3'd2,
    SH_LEFT  = 3'd3,
    SH_RIGHT = 3'd4
  } op_kind_e;

  // True when the class is one of the shift forms.
  function automatic logic is_shift(input op_kind_e k);
    return (k == SH_LEFT) || (k == SH_RIGHT);
  endfunction

  // Move a word-form position (0..half-1) into the low word of a 64-bit field.
  function automatic logic [5:0] word_pos(input logic [4:0] p);
    return {1'b1, p};
  endfunction

endpackage

// File: rtl/rms_rot_stage.sv
module rms_rot_stage #(
  parameter int W    = 64,
  parameter int STEP = 1
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   sel,
  output logic [W-1:0] dout
);
  logic [2*W-1:0] dbl;
  assign dbl = {din, din};

  always_comb begin
    unique case (sel)
      2'd0: dout = din;
      2'd1: dout = dbl[2*W-1-STEP   -: W];
      2'd2: dout = dbl[2*W-1-2*STEP -: W];
      default: dout = dbl[2*W-1-3*STEP -: W];
    endcase
  end
endmodule

// File: rtl/rms_rotator.sv
module rms_rotator #(
  parameter int W = 64,
  localparam int PW = $clog2(W),
  localparam int STAGES = PW / 2
) (
  input  logic [W-1:0]  din,
  input  logic [PW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] chain [STAGES+1];
  assign chain[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    rms_rot_stage #(.W(W), .STEP(4 ** s)) stage_i (
      .din (chain[s]),
      .sel (amt[2*s+1 -: 2]),
      .dout(chain[s+1])
    );
  end

  assign dout = chain[STAGES];
endmodule

// File: rtl/rms_mask_gen.sv
module rms_mask_gen #(
  parameter int W          = 64,
  parameter bit FROM_BEGIN = 1'b1,
  localparam int PW = $clog2(W)
) (
  input  logic [PW-1:0] pos,
  output logic [W-1:0]  mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int BE = W - 1 - i;
    if (FROM_BEGIN) begin : g_beg
      assign mask[i] = (pos <= PW'(BE));
    end else begin : g_end
      assign mask[i] = (pos >= PW'(BE));
    end
  end
endmodule

// File: rtl/rms_unit.sv
module rms_unit #(
  parameter int W = 64,
  localparam int PW = $clog2(W),
  localparam int HALF = W / 2
) (
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  ins_b,
  input  logic [PW:0]   shamt,
  input  logic [PW-1:0] mbeg,
  input  logic [PW-1:0] mend,
  input  logic [2:0]    op_cls,
  input  logic          word_mode,
  input  logic          arith,
  input  logic          merge_en,
  output logic [W-1:0]  result,
  output logic          ca_out
);
  import rms_pkg::*;

  op_kind_e      cls;
  logic [W-1:0]  din, rot_out, beg_mask, end_mask, sel_mask, fill, lost_bits, keep_w;
  logic [PW-1:0] sh_amt, rot_amt, pos_b, pos_e, mb_e, me_e;
  logic          over, kill, wrap, is_rot, sign_bit, sra_fill, is_shl;

  assign cls    = op_kind_e'(op_cls);
  assign is_rot = !is_shift(cls);
  assign is_shl = (cls == SH_LEFT);

  assign din = word_mode ? {src_a[HALF-1:0], src_a[HALF-1:0]} : src_a;

  always_comb begin
    sh_amt  = word_mode ? {1'b0, shamt[PW-2:0]} : shamt[PW-1:0];
    over    = word_mode ? shamt[PW-1] : shamt[PW];
    mb_e    = word_mode ? word_pos(mbeg[PW-2:0]) : mbeg;
    me_e    = word_mode ? word_pos(mend[PW-2:0]) : mend;
    rot_amt = sh_amt;
    pos_b   = mb_e;
    pos_e   = me_e;
    wrap    = 1'b0;
    kill    = 1'b0;
    case (cls)
      RM_LEFT:  pos_e = '1;
      RM_RIGHT: pos_b = '0;
      SH_LEFT: begin
        pos_b = word_mode ? PW'(HALF) : '0;
        pos_e = '1 - sh_amt;
        kill  = over;
      end
      SH_RIGHT: begin
        rot_amt = '0 - sh_amt;
        pos_b   = word_mode ? word_pos(shamt[PW-2:0]) : shamt[PW-1:0];
        pos_e   = '1;
        kill    = over;
      end
      default: wrap = (mb_e > me_e);
    endcase
  end

  rms_rotator #(.W(W)) rot_i (
    .din (din),
    .amt (rot_amt),
    .dout(rot_out)
  );

  rms_mask_gen #(.W(W), .FROM_BEGIN(1'b1)) beg_i (.pos(pos_b), .mask(beg_mask));
  rms_mask_gen #(.W(W), .FROM_BEGIN(1'b0)) end_i (.pos(pos_e), .mask(end_mask));

  assign sel_mask = kill ? '0 : (wrap ? (beg_mask | end_mask) : (beg_mask & end_mask));

  assign sign_bit = word_mode ? src_a[HALF-1] : src_a[W-1];
  assign sra_fill = (cls == SH_RIGHT) && arith && sign_bit;
  assign fill     = (is_rot && merge_en) ? ins_b : {W{sra_fill}};
  assign result   = (rot_out & sel_mask) | (fill & ~sel_mask);

  assign keep_w    = word_mode ? {{HALF{1'b0}}, {HALF{1'b1}}} : '1;
  assign lost_bits = rot_out & ~sel_mask & keep_w;
  assign ca_out    = sra_fill && (|lost_bits);
endmodule

// File: rtl/rms_unit_chk.sv
module rms_unit_chk #(
  parameter int W = 64,
  localparam int HALF = W / 2
) (
  input logic [W-1:0] din,
  input logic [W-1:0] rot_out,
  input logic [W-1:0] sel_mask,
  input logic [W-1:0] result,
  input logic [W-1:0] ins_b,
  input logic         ca_out,
  input logic         kill,
  input logic         sra_fill,
  input logic         is_rot,
  input logic         is_shl,
  input logic         merge_en,
  input logic         word_mode
);
  always_comb begin
    // R11: a rotation only moves bits, so the count of ones is kept
    assert_rot_popcount_R11: assert ($countones(rot_out) == $countones(din));
    // R1: bits inside the mask come from the rotator
    assert_in_mask_R1: assert ((result & sel_mask) == (rot_out & sel_mask));
    assert_merge_keep_R5: assert (!(is_rot && merge_en) ||
                                  ((result & ~sel_mask) == (ins_b & ~sel_mask)));
    assert_overflow_R9: assert (!kill || (result == {W{sra_fill}}));
    assert_carry_sign_R10: assert (!ca_out || sra_fill);
    assert_word_shl_R6: assert (!(is_shl && word_mode) || (result[W-1:HALF] == '0));
  end
endmodule

bind rms_unit rms_unit_chk #(.W(W)) chk_i (
  .din      (din),
  .rot_out  (rot_out),
  .sel_mask (sel_mask),
  .result   (result),
  .ins_b    (ins_b),
  .ca_out   (ca_out),
  .kill     (kill),
  .sra_fill (sra_fill),
  .is_rot   (is_rot),
  .is_shl   (is_shl),
  .merge_en (merge_en),
  .word_mode(word_mode)
);

// File: tb/rms_unit_tb.sv
module rms_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [63:0] src_a, ins_b, result;
  logic [6:0]  shamt;
  logic [5:0]  mbeg, mend;
  logic [2:0]  op_cls;
  logic        word_mode, arith, merge_en, ca_out;

  int n_chk = 0;
  int n_bad = 0;
  int wd    = 0;
  bit done  = 1'b0;

  rms_unit dut_i (
    .src_a(src_a), .ins_b(ins_b), .shamt(shamt), .mbeg(mbeg), .mend(mend),
    .op_cls(op_cls), .word_mode(word_mode), .arith(arith), .merge_en(merge_en),
    .result(result), .ca_out(ca_out)
  );

  // Reference: returns {carry, result}
  function automatic logic [64:0] ref_calc(
    input logic [63:0] a, b, input logic [6:0] sh, input logic [5:0] mb, me,
    input logic [2:0] cls, input logic wd_m, ar, mg);
    logic [63:0] x, r, m, res;
    logic signed [31:0] t32;
    logic signed [63:0] t64;
    logic c;
    int k, bm, em, n;
    c = 1'b0;
    res = '0;
    if (cls <= 3'd2) begin
      x  = wd_m ? {a[31:0], a[31:0]} : a;
      k  = wd_m ? int'(sh[4:0]) : int'(sh[5:0]);
      r  = (x << k) | (x >> (64 - k));
      bm = wd_m ? 32 + int'(mb[4:0]) : int'(mb);
      em = wd_m ? 32 + int'(me[4:0]) : int'(me);
      for (int be = 0; be < 64; be++) begin
        if (cls == 3'd1)      m[63-be] = (be >= bm);
        else if (cls == 3'd2) m[63-be] = (be <= em);
        else if (bm <= em)    m[63-be] = (be >= bm) && (be <= em);
        else                  m[63-be] = (be >= bm) || (be <= em);
      end
      res = (r & m) | (mg ? (b & ~m) : 64'd0);
    end else if (cls == 3'd3) begin
      if (wd_m) begin
        n = int'(sh[5:0]);
        res = (n >= 32) ? 64'd0 : {32'd0, a[31:0] << n};
      end else begin
        n = int'(sh);
        res = (n >= 64) ? 64'd0 : (a << n);
      end
    end else begin
      if (wd_m) begin
        n = int'(sh[5:0]);
        if (ar) begin
          t32 = $signed(a[31:0]) >>> n;
          res = {{32{t32[31]}}, t32};
          c = a[31] && ((n >= 32) ? (|a[31:0]) : (|(a[31:0] & ((32'h1 << n) - 32'h1))));
        end else begin
          res = {32'd0, a[31:0] >> n};
        end
      end else begin
        n = int'(sh);
        if (ar) begin
          t64 = $signed(a) >>> n;
          res = t64;
          c = a[63] && ((n >= 64) ? (|a) : (|(a & ((64'h1 << n) - 64'h1))));
        end else begin
          res = a >> n;
        end
      end
    end
    return {c, res};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, exp_v);
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp_v);
    end
  endtask

  // Apply one vector, wait, compare result and carry with the reference
  task automatic run_vec(input string tag, input logic [63:0] a, b, input logic [6:0] sh,
                         input logic [5:0] mb, me, input logic [2:0] cls,
                         input logic wd_m, ar, mg);
    logic [64:0] e;
    @(negedge clk);
    src_a = a; ins_b = b; shamt = sh; mbeg = mb; mend = me;
    op_cls = cls; word_mode = wd_m; arith = ar; merge_en = mg;
    #1;
    e = ref_calc(a, b, sh, mb, me, cls, wd_m, ar, mg);
    chk(tag, result, e[63:0]);
    chk({tag, " carry"}, {63'd0, ca_out}, {63'd0, e[64]});
  endtask

  localparam logic [63:0] PAT = 64'h8123_4567_89AB_CDEF;
  localparam logic [63:0] INS = 64'hA5A5_5A5A_F0F0_0F0F;

  task automatic t_reset_state;
    run_vec("R12 idle zero", '0, '0, '0, '0, '0, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rotate_sweep;
    for (int k = 0; k < 64; k++)
      run_vec("R11 rotate", PAT, INS, 7'(k), 6'd0, 6'd63, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_both_masks;
    run_vec("R1 inner", PAT, INS, 7'd13, 6'd10, 6'd40, 3'd0, 1'b0, 1'b0, 1'b0);
    run_vec("R1 wrap", PAT, INS, 7'd5, 6'd50, 6'd7, 3'd0, 1'b0, 1'b0, 1'b0);
    run_vec("R1 single", PAT, INS, 7'd0, 6'd63, 6'd63, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clear_left;
    run_vec("R2 me=0", PAT, INS, 7'd9, 6'd20, 6'd0, 3'd1, 1'b0, 1'b0, 1'b0);
    run_vec("R2 me=37", PAT, INS, 7'd9, 6'd20, 6'd37, 3'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clear_right;
    run_vec("R3 mb=0", PAT, INS, 7'd3, 6'd0, 6'd44, 3'd2, 1'b0, 1'b0, 1'b0);
    run_vec("R3 mb=61", PAT, INS, 7'd3, 6'd61, 6'd44, 3'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_word_rot;
    run_vec("R4 word", PAT, INS, 7'd7, 6'd4, 6'd27, 3'd0, 1'b1, 1'b0, 1'b0);
    run_vec("R4 word wrap", PAT, INS, 7'd31, 6'd24, 6'd3, 3'd0, 1'b1, 1'b0, 1'b0);
    run_vec("R4 word hi ignored", PAT, INS, 7'b1100111, 6'b110100, 6'b111011, 3'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_merge;
    run_vec("R5 insert dword", PAT, INS, 7'd16, 6'd16, 6'd47, 3'd0, 1'b0, 1'b0, 1'b1);
    run_vec("R5 insert word", PAT, INS, 7'd8, 6'd0, 6'd23, 3'd0, 1'b1, 1'b0, 1'b1);
    run_vec("R5 insert wrap", PAT, INS, 7'd40, 6'd60, 6'd2, 3'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_shifts;
    run_vec("R6 shl dword", PAT, INS, 7'd12, '0, '0, 3'd3, 1'b0, 1'b0, 1'b0);
    run_vec("R6 shl word", PAT, INS, 7'd5, '0, '0, 3'd3, 1'b1, 1'b0, 1'b0);
    run_vec("R6 shl merge ignored", PAT, INS, 7'd63, '0, '0, 3'd3, 1'b0, 1'b0, 1'b1);
    run_vec("R7 srl dword", PAT, INS, 7'd20, '0, '0, 3'd4, 1'b0, 1'b0, 1'b0);
    run_vec("R7 srl word", PAT, INS, 7'd31, '0, '0, 3'd4, 1'b1, 1'b0, 1'b0);
    run_vec("R8 sra dword neg", PAT, INS, 7'd9, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
    run_vec("R8 sra word neg", PAT, INS, 7'd4, '0, '0, 3'd4, 1'b1, 1'b1, 1'b0);
    run_vec("R8 sra word pos", 64'hFFFF_FFFF_7000_0001, INS, 7'd3, '0, '0, 3'd4, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_overflow;
    run_vec("R9 shl dword 64", PAT, INS, 7'd64, '0, '0, 3'd3, 1'b0, 1'b0, 1'b0);
    run_vec("R9 shl word 32", PAT, INS, 7'd32, '0, '0, 3'd3, 1'b1, 1'b0, 1'b0);
    run_vec("R9 srl dword 127", PAT, INS, 7'd127, '0, '0, 3'd4, 1'b0, 1'b0, 1'b0);
    run_vec("R9 sra dword 64", PAT, INS, 7'd64, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
    run_vec("R9 sra word 40", PAT, INS, 7'd40, '0, '0, 3'd4, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_carry;
    run_vec("R10 neg lost zeros", 64'h8000_0000_0000_0100, INS, 7'd8, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
    run_vec("R10 neg lost one", 64'h8000_0000_0000_0180, INS, 7'd8, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
    run_vec("R10 pos lost one", 64'h7000_0000_0000_00FF, INS, 7'd8, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
    run_vec("R10 word neg", 64'h0000_0000_8000_0003, INS, 7'd1, '0, '0, 3'd4, 1'b1, 1'b1, 1'b0);
    run_vec("R10 word hi ignored", 64'hFFFF_FFFF_8000_0000, INS, 7'd4, '0, '0, 3'd4, 1'b1, 1'b1, 1'b0);
    run_vec("R10 shift 0", PAT, INS, 7'd0, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
  endtask

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 7);
    return v ^ (v << 17);
  endfunction

  task automatic t_mixed;
    logic [63:0] s, a, b;
    s = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 400; i++) begin
      s = xs(s); a = s;
      s = xs(s); b = s;
      s = xs(s);
      run_vec("R1-R10 mixed", a, b, s[6:0], s[12:7], s[18:13], 3'(int'(s[22:20]) % 5),
              s[23], s[24], s[25]);
    end
  endtask

  task automatic t_no_state;
    // R12: repeat an early vector after many others; output must match again
    run_vec("R12 repeat", PAT, INS, 7'd5, 6'd50, 6'd7, 3'd0, 1'b0, 1'b0, 1'b0);
    run_vec("R12 repeat sra", PAT, INS, 7'd9, '0, '0, 3'd4, 1'b0, 1'b1, 1'b0);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (!done && wd >= WD_LIMIT) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", wd, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    src_a = '0; ins_b = '0; shamt = '0; mbeg = '0; mend = '0;
    op_cls = '0; word_mode = 1'b0; arith = 1'b0; merge_en = 1'b0;
    t_reset_state();
    t_rotate_sweep();
    t_both_masks();
    t_clear_left();
    t_clear_right();
    t_word_rot();
    t_merge();
    t_shifts();
    t_overflow();
    t_carry();
    t_mixed();
    t_no_state();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule